// File: doc/BRIEF.md
# Vector Issue Hazard Interlock

This block decides, cycle by cycle, whether the instruction offered by the decoder of a small four-lane vector coprocessor may issue. The decoder presents an operation class, a destination vector register with a lane mask, two source registers with their lane masks, and a latency in cycles. The block answers with a combinational `stall`. The decoder holds its instruction unchanged until `stall` is low in a cycle where `in_valid` is high, and the instruction issues in that cycle.

Three kinds of wait are enforced. Multiply-add class results are tracked per lane through a fixed pipeline of write-back stages. Readers of a pending lane wait, and readers of other lanes go ahead. The divide unit and the elementary-function unit each have a busy timer loaded from the latency code. The divide unit frees one cycle after its result is written. The elementary-function unit frees in its write-back cycle. Divide and elementary results never cause a lane hazard. The `q_stale` and `p_stale` outputs tell a reader that the scalar result register still holds the previous result, and `q_wr` and `p_wr` mark the cycle in which the new value lands.

Top module: `hzd_issue_ctl`

## Requirements
- R1: An accepted multiply-add instruction (class code 0) keeps its destination lanes pending for PIPE_DEPTH (default 3) cycles. A class 0, 1 or 2 instruction that reads a pending lane of that register stalls. A dependent instruction offered in the very next cycle stalls exactly 3 cycles. With `in_valid` low, `stall` is low.
- R2: The hazard check is per lane. Lane mask bit 3 is x, bit 2 is y, bit 1 is z and bit 0 is w. Reading another lane of a pending register does not stall.
- R3: A divide instruction (class code 1) accepted with latency L keeps the divide unit busy for L cycles. A second divide offered during those cycles stalls, and it issues in the cycle after `q_wr`.
- R4: After a divide issues, `q_stale` is high from the next cycle until the result is written. `q_wr` pulses for one cycle in the L-th cycle after issue. A busy divide unit causes no stall for multiply-add instructions.
- R5: The elementary-function unit (class code 2) frees in its own write-back cycle. A second elementary operation issues in the cycle where `p_wr` is high, one cycle earlier than a divide would.
- R6: A wait-for-divide instruction (class code 4) stalls while `q_stale` is high. A wait-for-elementary instruction (class code 5) stalls while `p_stale` is high, including the write-back cycle.
- R7: An integer instruction (class code 3) never stalls and creates no pending lanes.
- R8: A stalled instruction loads no timer and enters no pending lane. The timers of units already busy keep counting.
- R9: A latency code of 0 is treated as 1.
- R10: A synchronous active-low reset clears all pending lanes and both timers.
- R11: Divide and elementary-function instructions also stall when they read a pending lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoder offers an instruction |
| in_class | input | 3 | 0 multiply-add, 1 divide, 2 elementary, 3 integer, 4 wait-divide, 5 wait-elementary |
| in_dst | input | REG_W | Destination vector register |
| in_dmask | input | 4 | Destination lane mask (x y z w, bit 3 down to 0) |
| in_src0 | input | REG_W | First source register |
| in_smask0 | input | 4 | First source lane mask |
| in_src1 | input | REG_W | Second source register |
| in_smask1 | input | 4 | Second source lane mask |
| in_lat | input | LAT_W | Unit latency in cycles for divide and elementary operations |
| stall | output | 1 | Offered instruction must be held |
| q_stale | output | 1 | Divide in flight, readers see the previous divide result |
| q_wr | output | 1 | Divide result is written this cycle |
| p_stale | output | 1 | Elementary operation in flight, readers see the previous result |
| p_wr | output | 1 | Elementary result is written this cycle |

## Verification
The assertions check on every cycle the rules that depend only on present and one-cycle-old port values. Integer and idle cycles never stall. A busy divide unit always blocks divide and wait-divide instructions. A busy elementary unit blocks before its write-back cycle. Write pulses fall inside a busy window, the divide unit clears after its write, and reset clears both units. The exact stall counts for lane hazards, the per-lane distinction, the one-cycle difference in release between the two units, latency code 0, and the fact that a held instruction loads no timer are shown only by the bench's cycle-counted scenarios.

// File: rtl/hzd_pkg.sv
// Shared definitions for the vector issue hazard interlock.
// Assumes a four-lane vector register file (x, y, z, w).
package hzd_pkg;
    localparam int LANES = 4;

    typedef enum logic [2:0] {
        OPC_FMAC  = 3'd0,
        OPC_FDIV  = 3'd1,
        OPC_EFU   = 3'd2,
        OPC_IALU  = 3'd3,
        OPC_WAITQ = 3'd4,
        OPC_WAITP = 3'd5
    } op_class_e;
endpackage

// File: rtl/hzd_lane_board.sv
// Per-lane pending-write board. Each accepted multiply-add write travels
// through DEPTH shift stages and retires at the end of the last one.
// Every read port is compared with every stage.
// Assumes DEPTH >= 1. Stages advance every cycle, stalled or not.
module hzd_lane_board
    import hzd_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2,
    parameter int DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [REG_W-1:0]            push_reg,
    input  logic [LANES-1:0]            push_mask,
    input  logic [NSRC-1:0][REG_W-1:0]  rd_reg,
    input  logic [NSRC-1:0][LANES-1:0]  rd_mask,
    output logic                        hit
);
    logic [DEPTH-1:0]                 st_vld;
    logic [DEPTH-1:0][REG_W-1:0]      st_reg;
    logic [DEPTH-1:0][LANES-1:0]      st_mask;
    logic [DEPTH-1:0][NSRC-1:0]       st_hit;

    // Shift pending writes one stage per cycle; reset empties the board.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld  <= '0;
            st_reg  <= '0;
            st_mask <= '0;
        end else begin
            st_vld[0]  <= push;
            st_reg[0]  <= push_reg;
            st_mask[0] <= push_mask;
            for (int s = 1; s < DEPTH; s++) begin
                st_vld[s]  <= st_vld[s-1];
                st_reg[s]  <= st_reg[s-1];
                st_mask[s] <= st_mask[s-1];
            end
        end
    end

    // Compare each stage against each read port, lane by lane.
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        for (genvar n = 0; n < NSRC; n++) begin : g_src
            assign st_hit[s][n] = st_vld[s] && (st_reg[s] == rd_reg[n])
                                  && (|(st_mask[s] & rd_mask[n]));
        end
    end

    assign hit = |st_hit;
endmodule

// File: rtl/hzd_unit_timer.sv
// Busy timer for one long-latency unit. It loads the latency on start
// (0 counts as 1) and counts down to zero. The result lands in the cycle
// the count is 1. EARLY_FREE=1 releases the unit in that write cycle,
// EARLY_FREE=0 releases it one cycle later.
// Assumes start is only raised while busy is low.
module hzd_unit_timer #(
    parameter int LAT_W      = 6,
    parameter bit EARLY_FREE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    output logic             busy,
    output logic             active,
    output logic             wr_pulse
);
    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    logic [LAT_W-1:0] cnt;

    // Load on start, otherwise count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= (lat == '0) ? ONE : lat;
        else if (cnt != '0)
            cnt <= cnt - ONE;
    end

    assign active   = (cnt != '0);
    assign wr_pulse = (cnt == ONE);

    // Release point chosen per unit.
    if (EARLY_FREE) begin : g_early
        assign busy = (cnt > ONE);
    end else begin : g_late
        assign busy = active;
    end
endmodule

// File: rtl/hzd_issue_ctl.sv
// Issue stall controller for a four-lane vector coprocessor. It combines
// lane hazards from the pending-write board with resource hazards from
// the divide and elementary-function timers into one combinational stall.
// Assumes the decoder holds every issue input while stall is high.
module hzd_issue_ctl
    import hzd_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int LAT_W      = 6,
    parameter int PIPE_DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_class,
    input  logic [REG_W-1:0] in_dst,
    input  logic [3:0]       in_dmask,
    input  logic [REG_W-1:0] in_src0,
    input  logic [3:0]       in_smask0,
    input  logic [REG_W-1:0] in_src1,
    input  logic [3:0]       in_smask1,
    input  logic [LAT_W-1:0] in_lat,
    output logic             stall,
    output logic             q_stale,
    output logic             q_wr,
    output logic             p_stale,
    output logic             p_wr
);
    localparam int NSRC = 2;

    op_class_e                  cls;
    logic                       accept;
    logic                       reads_vec;
    logic                       lane_hit;
    logic                       q_busy;
    logic                       p_busy;
    logic [NSRC-1:0][REG_W-1:0] rd_reg;
    logic [NSRC-1:0][3:0]       rd_mask;

    assign cls     = op_class_e'(in_class);
    assign rd_reg  = {in_src1, in_src0};
    assign rd_mask = {in_smask1, in_smask0};

    // Classes whose vector sources are checked against pending lanes.
    assign reads_vec = (cls == OPC_FMAC) || (cls == OPC_FDIV) || (cls == OPC_EFU);

    // Combine lane and unit hazards into the stall decision.
    always_comb begin
        stall = 1'b0;
        if (in_valid) begin
            stall = (reads_vec && lane_hit)
                 || ((cls == OPC_FDIV)  && q_busy)
                 || ((cls == OPC_EFU)   && p_busy)
                 || ((cls == OPC_WAITQ) && q_stale)
                 || ((cls == OPC_WAITP) && p_stale);
        end
    end

    assign accept = in_valid && !stall;

    hzd_lane_board #(
        .REG_W (REG_W),
        .NSRC  (NSRC),
        .DEPTH (PIPE_DEPTH)
    ) u_board (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept && (cls == OPC_FMAC)),
        .push_reg  (in_dst),
        .push_mask (in_dmask),
        .rd_reg    (rd_reg),
        .rd_mask   (rd_mask),
        .hit       (lane_hit)
    );

    hzd_unit_timer #(
        .LAT_W      (LAT_W),
        .EARLY_FREE (1'b0)
    ) u_div_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && (cls == OPC_FDIV)),
        .lat      (in_lat),
        .busy     (q_busy),
        .active   (q_stale),
        .wr_pulse (q_wr)
    );

    hzd_unit_timer #(
        .LAT_W      (LAT_W),
        .EARLY_FREE (1'b1)
    ) u_efu_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && (cls == OPC_EFU)),
        .lat      (in_lat),
        .busy     (p_busy),
        .active   (p_stale),
        .wr_pulse (p_wr)
    );
endmodule

// File: rtl/hzd_issue_ctl_chk.sv
// Port-level property checker for hzd_issue_ctl, attached with bind.
module hzd_issue_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [2:0] in_class,
    input logic       stall,
    input logic       q_stale,
    input logic       q_wr,
    input logic       p_stale,
    input logic       p_wr
);
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !stall); // R1
    AST_IALU_NEVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd3) |-> !stall); // R7
    AST_DIV_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd1 && q_stale) |-> stall); // R3
    AST_DIV_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stall && in_class == 3'd1) |=> q_stale); // R3
    AST_Q_FREE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        q_wr |=> !q_stale); // R4
    AST_Q_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q_wr |-> q_stale); // R4
    AST_EFU_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd2 && p_stale && !p_wr) |-> stall); // R5
    AST_P_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        p_wr |-> p_stale); // R5
    AST_WAITQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd4 && q_stale) |-> stall); // R6
    AST_WAITP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd5 && p_stale) |-> stall); // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!q_stale && !p_stale)); // R10
endmodule

bind hzd_issue_ctl hzd_issue_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_class (in_class),
    .stall    (stall),
    .q_stale  (q_stale),
    .q_wr     (q_wr),
    .p_stale  (p_stale),
    .p_wr     (p_wr)
);

// File: tb/hzd_issue_ctl_bench.sv
module hzd_issue_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 23;

    // vld cls dst dmask s0 m0 s1 m1 lat exp{stall,q_stale,q_wr,p_stale,p_wr} req
    typedef struct packed {
        logic       vld;
        logic [2:0] cls;
        logic [4:0] dst;
        logic [3:0] dm;
        logic [4:0] s0;
        logic [3:0] m0;
        logic [4:0] s1;
        logic [3:0] m1;
        logic [5:0] lat;
        logic [4:0] exp_o;
        logic [3:0] req;
    } row_t;

    localparam row_t ROWS [NROWS] = '{
        '{1'b1, 3'd0, 5'd3, 4'b1000, 5'd1, 4'b1111, 5'd2, 4'b1111, 6'd0, 5'b00000, 4'd2}, // R2 write r3.x
        '{1'b1, 3'd0, 5'd4, 4'b0001, 5'd3, 4'b0100, 5'd0, 4'b0000, 6'd0, 5'b00000, 4'd2}, // R2 read r3.y
        '{1'b1, 3'd0, 5'd5, 4'b1111, 5'd3, 4'b1000, 5'd0, 4'b0000, 6'd0, 5'b10000, 4'd1}, // R1 read r3.x
        '{1'b1, 3'd0, 5'd5, 4'b1111, 5'd3, 4'b1000, 5'd0, 4'b0000, 6'd0, 5'b10000, 4'd1}, // R1
        '{1'b1, 3'd0, 5'd5, 4'b1111, 5'd3, 4'b1000, 5'd0, 4'b0000, 6'd0, 5'b00000, 4'd1}, // R1 retired
        '{1'b1, 3'd3, 5'd5, 4'b1111, 5'd5, 4'b1111, 5'd0, 4'b0000, 6'd0, 5'b00000, 4'd7}, // R7 integer
        '{1'b1, 3'd1, 5'd0, 4'b0000, 5'd6, 4'b1000, 5'd0, 4'b0000, 6'd4, 5'b00000, 4'd3}, // R3 div L=4
        '{1'b1, 3'd0, 5'd8, 4'b1111, 5'd7, 4'b1111, 5'd0, 4'b0000, 6'd0, 5'b01000, 4'd4}, // R4 no lane stall
        '{1'b1, 3'd1, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd2, 5'b11000, 4'd3}, // R3
        '{1'b1, 3'd1, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd2, 5'b11000, 4'd3}, // R3
        '{1'b1, 3'd1, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd2, 5'b11100, 4'd4}, // R4 write
        '{1'b1, 3'd1, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd2, 5'b00000, 4'd3}, // R3 issue
        '{1'b1, 3'd2, 5'd0, 4'b0000, 5'd9, 4'b1000, 5'd0, 4'b0000, 6'd3, 5'b01000, 4'd5}, // R5 efu L=3
        '{1'b1, 3'd2, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd5, 5'b11110, 4'd5}, // R5
        '{1'b1, 3'd2, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd5, 5'b10010, 4'd5}, // R5
        '{1'b1, 3'd2, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd5, 5'b00011, 4'd5}, // R5 issue on wr
        '{1'b1, 3'd5, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd0, 5'b10010, 4'd6}, // R6 waitp
        '{1'b1, 3'd5, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd0, 5'b10010, 4'd6}, // R6
        '{1'b1, 3'd5, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd0, 5'b10010, 4'd6}, // R6
        '{1'b1, 3'd5, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd0, 5'b10010, 4'd6}, // R6
        '{1'b1, 3'd5, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd0, 5'b10011, 4'd6}, // R6 wr cycle
        '{1'b1, 3'd5, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd0, 5'b00000, 4'd6}, // R6 released
        '{1'b0, 3'd0, 5'd0, 4'b0000, 5'd0, 4'b0000, 5'd0, 4'b0000, 6'd0, 5'b00000, 4'd1}  // R1 idle
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [2:0] in_class;
    logic [4:0] in_dst, in_src0, in_src1;
    logic [3:0] in_dmask, in_smask0, in_smask1;
    logic [5:0] in_lat;
    logic       stall, q_stale, q_wr, p_stale, p_wr;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_issue_ctl u_hzd_issue_ctl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_dmask(in_dmask), .in_src0(in_src0),
        .in_smask0(in_smask0), .in_src1(in_src1), .in_smask1(in_smask1),
        .in_lat(in_lat), .stall(stall), .q_stale(q_stale), .q_wr(q_wr),
        .p_stale(p_stale), .p_wr(p_wr)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] c, input logic [4:0] d,
                         input logic [3:0] dm, input logic [4:0] s0, input logic [3:0] m0,
                         input logic [5:0] l);
        in_valid = v; in_class = c; in_dst = d; in_dmask = dm;
        in_src0 = s0; in_smask0 = m0; in_src1 = '0; in_smask1 = '0; in_lat = l;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drive(1'b0, 3'd0, 5'd0, 4'd0, 5'd0, 4'd0, 6'd0);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 3'd0, 5'd0, 4'd0, 5'd0, 4'd0, 6'd0);
        repeat (2) @(negedge clk);
        #1;
        check("R10 reset stall", stall, 0);
        check("R10 reset q_stale", q_stale, 0);
        check("R10 reset p_stale", p_stale, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            in_valid = ROWS[r].vld; in_class = ROWS[r].cls; in_dst = ROWS[r].dst;
            in_dmask = ROWS[r].dm; in_src0 = ROWS[r].s0; in_smask0 = ROWS[r].m0;
            in_src1 = ROWS[r].s1; in_smask1 = ROWS[r].m1; in_lat = ROWS[r].lat;
            #1;
            n_run++;
            if ({stall, q_stale, q_wr, p_stale, p_wr} != ROWS[r].exp_o) begin
                n_fail++;
                $display("FAIL R%0d row %0d actual=%b expected=%b", ROWS[r].req, r,
                         {stall, q_stale, q_wr, p_stale, p_wr}, ROWS[r].exp_o);
            end
        end
        idle(6);

        // R1: dependent read right after the write stalls exactly 3 cycles
        begin
            int stalls = 0;
            @(negedge clk); drive(1'b1, 3'd0, 5'd10, 4'b1000, 5'd0, 4'd0, 6'd0);
            #1; check("R1 producer issues", stall, 0);
            for (int i = 0; i < 8; i++) begin
                @(negedge clk); drive(1'b1, 3'd0, 5'd13, 4'b1111, 5'd10, 4'b1000, 6'd0);
                #1;
                if (!stall) break;
                stalls++;
            end
            check("R1 stall cycles", stalls, 3);
        end
        idle(5);

        // R11: divide and elementary readers of a pending lane stall
        @(negedge clk); drive(1'b1, 3'd0, 5'd11, 4'b0010, 5'd0, 4'd0, 6'd0);
        @(negedge clk); drive(1'b1, 3'd1, 5'd0, 4'd0, 5'd11, 4'b0010, 6'd3);
        #1; check("R11 divide reads pending lane", stall, 1);
        in_class = 3'd2;
        #1; check("R11 elementary reads pending lane", stall, 1);
        idle(5);

        // R8: held divide does not restart the busy divide timer
        @(negedge clk); drive(1'b1, 3'd1, 5'd0, 4'd0, 5'd0, 4'd0, 6'd6);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk); drive(1'b1, 3'd1, 5'd0, 4'd0, 5'd0, 4'd0, 6'd2);
            #1; check("R8 second divide held", stall, 1);
        end
        @(negedge clk); drive(1'b0, 3'd0, 5'd0, 4'd0, 5'd0, 4'd0, 6'd0);
        @(negedge clk); #1; check("R8 no early write", q_wr, 0);
        @(negedge clk); #1; check("R8 write at original time", q_wr, 1);
        @(negedge clk); #1; check("R8 divide idle after write", q_stale, 0);

        // R8: held elementary op loads no timer
        @(negedge clk); drive(1'b1, 3'd0, 5'd12, 4'b1000, 5'd0, 4'd0, 6'd0);
        @(negedge clk); drive(1'b1, 3'd2, 5'd0, 4'd0, 5'd12, 4'b1000, 6'd9);
        #1; check("R8 elementary held", stall, 1);
        @(negedge clk); drive(1'b0, 3'd0, 5'd0, 4'd0, 5'd0, 4'd0, 6'd0);
        #1; check("R8 elementary timer not loaded", p_stale, 0);
        @(negedge clk); #1; check("R8 elementary still idle", p_stale, 0);
        idle(4);

        // R9: latency code 0 behaves as 1
        @(negedge clk); drive(1'b1, 3'd1, 5'd0, 4'd0, 5'd0, 4'd0, 6'd0);
        @(negedge clk); drive(1'b0, 3'd0, 5'd0, 4'd0, 5'd0, 4'd0, 6'd0);
        #1; check("R9 busy one cycle", q_stale, 1);
        check("R9 write next cycle", q_wr, 1);
        @(negedge clk); #1; check("R9 idle after", q_stale, 0);

        // R6: wait-for-divide holds until the divide clears
        @(negedge clk); drive(1'b1, 3'd1, 5'd0, 4'd0, 5'd0, 4'd0, 6'd3);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); drive(1'b1, 3'd4, 5'd0, 4'd0, 5'd0, 4'd0, 6'd0);
            #1; check("R6 waitq held", stall, 1);
        end
        @(negedge clk); #1; check("R6 waitq released", stall, 0);
        idle(2);

        // R10: reset in the middle of activity
        @(negedge clk); drive(1'b1, 3'd1, 5'd0, 4'd0, 5'd0, 4'd0, 6'd20);
        @(negedge clk); drive(1'b1, 3'd0, 5'd14, 4'b1111, 5'd0, 4'd0, 6'd0);
        @(negedge clk); drive(1'b1, 3'd2, 5'd0, 4'd0, 5'd0, 4'd0, 6'd20);
        @(negedge clk); rst_n = 1'b0; drive(1'b0, 3'd0, 5'd0, 4'd0, 5'd0, 4'd0, 6'd0);
        @(negedge clk); rst_n = 1'b1;
        #1; check("R10 divide cleared", q_stale, 0);
        check("R10 elementary cleared", p_stale, 0);
        drive(1'b1, 3'd0, 5'd15, 4'd0, 5'd14, 4'b1111, 6'd0);
        #1; check("R10 lanes cleared", stall, 0);
        in_class = 3'd1;
        #1; check("R10 divide free", stall, 0);
        idle(2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule